// File: doc/BRIEF.md
# Two-Channel Converter Data Staging Block

This block is the digital side of a two-channel digital-to-analog converter. Software, or a DMA engine, writes sample words into a small register window. Each write is realigned into a 12-bit staging value for the channel or channels it addresses. A per-channel output register feeds the converter. It takes the staged value either one cycle after the write, when triggering is off for that channel, or on the trigger event selected for that channel.

A trigger can come from several timer event lines, from one external line, or from a software trigger register. The timer and external lines are resynchronised and edge-detected, so each rising edge counts once. When DMA is enabled for a channel, that channel raises a one-cycle request each time a trigger moves data into its output register. The DMA engine then supplies the next sample. Packed dual words can stage both channels with a single write.

Top module: `dac_hold_frontend`

## Requirements
- R1: After reset both output codes, both DMA request lines and both software-trigger pending bits are zero.
- R2: With a channel enabled and its trigger mode off, its output code equals its staging value from the previous cycle. A write appears on the output one clock after the write edge.
- R3: Single-channel write addresses are: channel 0 at addresses 0, 1, 2 and channel 1 at addresses 3, 4, 5. For each channel the three addresses take 12-bit right-aligned (data bits 11:0), 12-bit left-aligned (bits 15:4, bits 3:0 dropped) and 8-bit (bits 7:0, stored as the upper 8 bits with the low 4 bits zero), in that order.
- R4: Dual writes stage both channels from one word. Address 6 takes bits 11:0 for channel 0 and bits 27:16 for channel 1. Address 7 takes bits 15:4 and bits 31:20. Address 8 takes 8-bit values from bits 7:0 and bits 15:8.
- R5: With trigger mode on, an output code changes only on that channel's selected source. Select values 0 to 5 pick timer lines 0 to 5, 6 picks the external line and 7 picks software. Events on sources that are not selected have no effect.
- R6: A rising edge on a timer or external line moves data once, three clock edges after the line is first sampled high. A line held high causes no further transfer.
- R7: Writing address 9 sets pending bit c for each set data bit c (c = 0, 1). The bit reads high for one cycle and clears itself at the next edge, which performs the transfer on a channel set to select 7.
- R8: A channel with DMA enabled pulses its request line for exactly one cycle, in the same cycle its output takes a triggered value. A channel with DMA disabled never raises its request.
- R9: A disabled channel drives code zero, ignores triggers and raises no DMA request. Writes to its staging register are still kept.
- R10: When a trigger and a write to the same channel's staging register fall on the same edge, the output takes the previous staging value. The new value waits for the next trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 32 | Register write data |
| ch_en | input | 2 | Per-channel enable |
| trig_en | input | 2 | Per-channel trigger mode |
| dma_en | input | 2 | Per-channel DMA request enable |
| trig_sel0 | input | SEL_W | Trigger source select, channel 0 |
| trig_sel1 | input | SEL_W | Trigger source select, channel 1 |
| tmr_evt | input | NUM_TMR | Asynchronous timer event lines |
| ext_evt | input | 1 | Asynchronous external trigger line |
| code0 | output | 12 | Output code, channel 0 |
| code1 | output | 12 | Output code, channel 1 |
| dma_req | output | 2 | One-cycle DMA request per channel |
| sw_pend | output | 2 | Software trigger pending bits |

## Verification
Two functions can land on the same clock edge: a trigger transfer into the output register, and a bus write into the same channel's staging register. The bench lines these up on purpose. It raises a timer line, counts the synchroniser edges, and places a channel-0 write so that it lands on the edge that performs the transfer. The result is judged by the output code, which must show the older staged value, and by a later trigger, which must bring out the newer one.

// File: rtl/dac_hold_frontend.sv
module dac_hold_frontend #(
  parameter int NUM_TMR = 6,
  parameter int AW      = 4,
  parameter int SEL_W   = $clog2(NUM_TMR + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [1:0]         ch_en,
  input  logic [1:0]         trig_en,
  input  logic [1:0]         dma_en,
  input  logic [SEL_W-1:0]   trig_sel0,
  input  logic [SEL_W-1:0]   trig_sel1,
  input  logic [NUM_TMR-1:0] tmr_evt,
  input  logic               ext_evt,
  output logic [11:0]        code0,
  output logic [11:0]        code1,
  output logic [1:0]         dma_req,
  output logic [1:0]         sw_pend
);
  localparam int SRC_N   = NUM_TMR + 1;
  localparam int SEL_SW  = NUM_TMR + 1;
  localparam logic [AW-1:0] A_C0_R12 = AW'(0);
  localparam logic [AW-1:0] A_C0_L12 = AW'(1);
  localparam logic [AW-1:0] A_C0_R8  = AW'(2);
  localparam logic [AW-1:0] A_C1_R12 = AW'(3);
  localparam logic [AW-1:0] A_C1_L12 = AW'(4);
  localparam logic [AW-1:0] A_C1_R8  = AW'(5);
  localparam logic [AW-1:0] A_D_R12  = AW'(6);
  localparam logic [AW-1:0] A_D_L12  = AW'(7);
  localparam logic [AW-1:0] A_D_R8   = AW'(8);
  localparam logic [AW-1:0] A_SWTRG  = AW'(9);
  localparam logic [1:0] F_R12 = 2'd0;
  localparam logic [1:0] F_L12 = 2'd1;
  localparam logic [1:0] F_R8  = 2'd2;

  function automatic logic [11:0] realign(input logic [1:0] f, input logic [15:0] d);
    case (f)
      F_R12:   realign = d[11:0];
      F_L12:   realign = d[15:4];
      default: realign = {d[7:0], 4'h0};
    endcase
  endfunction

  logic [1:0]            hit;
  logic [1:0]            fmt;
  logic [1:0][15:0]      lane;
  logic [1:0][11:0]      hold;
  logic [1:0][11:0]      out_q;
  logic [1:0]            dma_q;
  logic [1:0]            sw_q;
  logic [1:0]            evt;
  logic [1:0][SEL_W-1:0] sel;
  logic [SRC_N-1:0]      s1, s2, s3, rise;

  always_comb begin
    hit     = 2'b00;
    fmt     = F_R12;
    lane[0] = wr_data[15:0];
    lane[1] = wr_data[15:0];
    if (wr_en) begin
      case (wr_addr)
        A_C0_R12: begin hit = 2'b01; fmt = F_R12; end
        A_C0_L12: begin hit = 2'b01; fmt = F_L12; end
        A_C0_R8:  begin hit = 2'b01; fmt = F_R8;  end
        A_C1_R12: begin hit = 2'b10; fmt = F_R12; end
        A_C1_L12: begin hit = 2'b10; fmt = F_L12; end
        A_C1_R8:  begin hit = 2'b10; fmt = F_R8;  end
        A_D_R12:  begin hit = 2'b11; fmt = F_R12; lane[1] = wr_data[31:16]; end
        A_D_L12:  begin hit = 2'b11; fmt = F_L12; lane[1] = wr_data[31:16]; end
        A_D_R8:   begin hit = 2'b11; fmt = F_R8;  lane[1] = {8'h00, wr_data[15:8]}; end
        default:  hit = 2'b00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
      sw_q <= 2'b00;
    end else begin
      s1 <= {ext_evt, tmr_evt};
      s2 <= s1;
      s3 <= s2;
      sw_q <= (wr_en && wr_addr == A_SWTRG) ? wr_data[1:0] : 2'b00;
    end
  end

  assign rise = s2 & ~s3;
  assign sel  = {trig_sel1, trig_sel0};

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      evt[c] = 1'b0;
      if (int'(sel[c]) == SEL_SW) evt[c] = sw_q[c];
      for (int i = 0; i < SRC_N; i++)
        if (int'(sel[c]) == i) evt[c] = rise[i];
      evt[c] = evt[c] & ch_en[c] & trig_en[c];
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold[c]  <= '0;
        out_q[c] <= '0;
        dma_q[c] <= 1'b0;
      end else begin
        if (hit[c]) hold[c] <= realign(fmt, lane[c]);
        if (!ch_en[c])                out_q[c] <= '0;
        else if (!trig_en[c] || evt[c]) out_q[c] <= hold[c];
        dma_q[c] <= evt[c] & dma_en[c];
      end
    end
  end

  assign code0   = out_q[0];
  assign code1   = out_q[1];
  assign dma_req = dma_q;
  assign sw_pend = sw_q;
endmodule

// File: rtl/dac_hold_frontend_chk.sv
module dac_hold_frontend_chk #(
  parameter int AW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [1:0]      ch_en,
  input logic [1:0]      trig_en,
  input logic [1:0]      dma_en,
  input logic [11:0]     code0,
  input logic [11:0]     code1,
  input logic [1:0]      dma_req,
  input logic [1:0]      sw_pend,
  input logic [1:0][11:0] hold
);
  logic [1:0][11:0] code;
  assign code = {code1, code0};

  for (genvar c = 0; c < 2; c++) begin : g_a
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |=> code[c] == 12'h000); // R9
    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[c] && !trig_en[c]) |=> code[c] == $past(hold[c])); // R2
    AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[c] |-> $past(dma_en[c] && ch_en[c] && trig_en[c])); // R8
    AST_DMA_MARKS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[c] && trig_en[c] && dma_en[c]) |=> ($stable(code[c]) || dma_req[c])); // R8
    AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_pend[c] && !(wr_en && wr_addr == AW'(9))) |=> !sw_pend[c]); // R7
  end
endmodule

bind dac_hold_frontend dac_hold_frontend_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .ch_en(ch_en), .trig_en(trig_en), .dma_en(dma_en),
  .code0(code0), .code1(code1), .dma_req(dma_req), .sw_pend(sw_pend),
  .hold(hold)
);

// File: tb/tb_dac_hold_frontend.sv
module tb_dac_hold_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  ch_en = 2'b00, trig_en = 2'b00, dma_en = 2'b00;
  logic [2:0]  trig_sel0 = '0, trig_sel1 = '0;
  logic [5:0]  tmr_evt = '0;
  logic        ext_evt = 1'b0;
  logic [11:0] code0, code1;
  logic [1:0]  dma_req, sw_pend;
  int n_chk = 0, n_bad = 0;

  dac_hold_frontend dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ch_en(ch_en), .trig_en(trig_en), .dma_en(dma_en),
    .trig_sel0(trig_sel0), .trig_sel1(trig_sel1),
    .tmr_evt(tmr_evt), .ext_evt(ext_evt),
    .code0(code0), .code1(code1), .dma_req(dma_req), .sw_pend(sw_pend)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 code0", 32'(code0), 0);
    check("R1 code1", 32'(code1), 0);
    check("R1 dma", 32'(dma_req), 0);
    check("R1 swpend", 32'(sw_pend), 0);
  endtask

  task automatic t_pass;
    @(negedge clk); ch_en = 2'b11; trig_en = 2'b00;
    wr(4'd0, 32'h0000_0ABC); idle(1); check("R2 r12 ch0", 32'(code0), 32'hABC);
    wr(4'd1, 32'h0000_1237); idle(1); check("R3 l12 ch0", 32'(code0), 32'h123);
    wr(4'd2, 32'h0000_F15A); idle(1); check("R3 r8 ch0", 32'(code0), 32'h5A0);
    wr(4'd3, 32'h0000_F789); idle(1); check("R3 r12 ch1", 32'(code1), 32'h789);
    check("R3 ch0 untouched", 32'(code0), 32'h5A0);
  endtask

  task automatic t_dual;
    wr(4'd6, 32'hF0DE_F123); idle(1);
    check("R4 dr12 ch0", 32'(code0), 32'h123); check("R4 dr12 ch1", 32'(code1), 32'h0DE);
    wr(4'd7, 32'hABC5_4561); idle(1);
    check("R4 dl12 ch0", 32'(code0), 32'h456); check("R4 dl12 ch1", 32'(code1), 32'hABC);
    wr(4'd8, 32'h0000_3412); idle(1);
    check("R4 dr8 ch0", 32'(code0), 32'h120); check("R4 dr8 ch1", 32'(code1), 32'h340);
  endtask

  task automatic t_trig;
    @(negedge clk); trig_en = 2'b11; trig_sel0 = 3'd2; trig_sel1 = 3'd7; dma_en = 2'b01;
    wr(4'd6, 32'h0222_0111); idle(2);
    check("R5 held ch0", 32'(code0), 32'h120); check("R5 held ch1", 32'(code1), 32'h340);
    @(negedge clk); tmr_evt[3] = 1'b1; idle(4); tmr_evt[3] = 1'b0; idle(3);
    check("R5 wrong source", 32'(code0), 32'h120);
    @(negedge clk); tmr_evt[2] = 1'b1;
    idle(2); check("R6 not yet", 32'(code0), 32'h120);
    idle(1); check("R6 moved", 32'(code0), 32'h111); check("R8 dma pulse", 32'(dma_req), 32'h1);
    idle(1); check("R8 dma one cycle", 32'(dma_req), 0);
    wr(4'd0, 32'h0000_0333); idle(6);
    check("R6 level no retrigger", 32'(code0), 32'h111);
    tmr_evt[2] = 1'b0; idle(3);
    wr(4'd9, 32'h0000_0002);
    check("R7 pending set", 32'(sw_pend), 32'h2);
    idle(1);
    check("R7 sw moved", 32'(code1), 32'h222); check("R7 self clear", 32'(sw_pend), 0);
    check("R8 ch1 dma off", 32'(dma_req), 0);
    @(negedge clk); trig_sel0 = 3'd6; ext_evt = 1'b1; idle(3);
    check("R6 external", 32'(code0), 32'h333);
    ext_evt = 1'b0; idle(3);
  endtask

  task automatic t_disable;
    @(negedge clk); ch_en = 2'b01; idle(1);
    check("R9 off zero", 32'(code1), 0);
    wr(4'd9, 32'h0000_0002); idle(2);
    check("R9 trig ignored", 32'(code1), 0); check("R9 no dma", 32'(dma_req), 0);
    wr(4'd3, 32'h0000_0999);
    @(negedge clk); ch_en = 2'b11; trig_en = 2'b01; idle(1);
    check("R9 write kept while off", 32'(code1), 32'h999);
  endtask

  task automatic t_collide;
    @(negedge clk); trig_sel0 = 3'd2;
    wr(4'd0, 32'h0000_0444);
    @(negedge clk); tmr_evt[2] = 1'b1; idle(3);
    check("R10 setup", 32'(code0), 32'h444);
    tmr_evt[2] = 1'b0; idle(3);
    @(negedge clk); tmr_evt[2] = 1'b1; idle(2);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h0000_0555;
    @(negedge clk); wr_en = 1'b0;
    check("R10 old value moved", 32'(code0), 32'h444);
    check("R8 dma on collide", 32'(dma_req), 32'h1);
    tmr_evt[2] = 1'b0; idle(3);
    @(negedge clk); tmr_evt[2] = 1'b1; idle(3);
    check("R10 new on next", 32'(code0), 32'h555);
    tmr_evt[2] = 1'b0; idle(2);
  endtask

  initial begin
    idle(3);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    t_reset;
    t_pass;
    t_dual;
    t_trig;
    t_disable;
    t_collide;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule